// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM whose bus carries one command on every clock. Each command is a read, a write, a deselect or a burst continue. Address, control and byte-write enables are captured on the rising edge. Data moves two active clocks after its command. Read data and write data share the same slot in the pipeline, so reads and writes can follow each other on consecutive clocks with no idle turnaround cycle.

The shared data bus is modelled as a separate write-data input and read-data output. A valid flag marks when the output would be driven. A clock-enable input, which is active low, freezes every internal register. Three chip selects qualify each new load. A burst-order input chooses between linear and interleaved beat ordering when a burst is loaded. After a load, continue commands step a two-bit beat counter and repeat the operation type of the load.

Top module: `pipe_sram`

## Requirements
- R1: A command is captured on a rising edge where `clk_en_n` is 0. For a read, the data is on `rdata` with `rdata_vld` high in the cycle after the second following active edge. For a write, `wdata` is sampled on that second active edge.
- R2: On a rising edge where `clk_en_n` is 1, every input is ignored and every internal register, including the array, keeps its value, so `rdata` and `rdata_vld` do not change.
- R3: A load (`burst_cont` = 0) selects the device only when `chip_sel` is 3'b111. `wr_n` = 0 makes the load a write and `wr_n` = 1 makes it a read. Any other chip-select value makes a deselect: the array is not written and `rdata_vld` is 0 in its data slot.
- R4: In a write, byte lane i (`wdata[8i+7:8i]`) is stored only when `lane_wr_n[i]` is 0, and lanes that are not written keep their contents. The byte enables are sampled with each command, including burst continues.
- R5: Reads and writes may alternate on consecutive active clocks, and every data slot carries its transfer with no idle cycle.
- R6: A continue (`burst_cont` = 1) repeats the type of the last load and ignores `wr_n`, `addr` and `chip_sel`. Let the loaded address be B and let k be the number of continues since the load, modulo 4. The upper address bits stay those of B. The low two bits are (B[1:0]+k) mod 4 when `ilv_mode` was 0 at the load, and B[1:0] XOR k when it was 1.
- R7: `rdata_vld` is 1 only in the data slot of a read while `out_en_n` is 0, and `out_en_n` acts combinationally. In write slots, deselect slots and while `out_en_n` is 1, `rdata_vld` is 0 and `rdata` reads 0.
- R8: A read issued on the clock after a write to the same address returns the newly written lanes merged with the old contents of the unwritten lanes.
- R9: Continue commands after a deselect stay deselected until the next load.
- R10: While `rst_n` is 0, all commands in flight are dropped, `rdata_vld` is 0 and the burst state is cleared, so a continue right after reset is a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; 1 stalls the block |
| chip_sel | input | 3 | Chip selects; all ones selects the device on a load |
| burst_cont | input | 1 | 0 loads a new command, 1 continues the burst |
| wr_n | input | 1 | On a load, 0 means write and 1 means read |
| lane_wr_n | input | 4 | Per-byte write enables, active low |
| ilv_mode | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data for the current write slot |
| out_en_n | input | 1 | Output enable, active low |
| rdata | output | 32 | Read data, 0 when not valid |
| rdata_vld | output | 1 | Output driven flag |

## Verification
The bench sweeps every low address with both burst orders and both operation types through six beats. If the wrap or the XOR ordering were wrong, data would land at the wrong word, and later read-backs would show it. It writes each of the sixteen byte masks and reads the word back on the very next clock. A design that forwarded the whole write word, or read the array one edge early, would return stale or wrong lanes. Stalls are placed inside write and read data slots, and a deselected burst is followed by reads of the words it covered. A design that let a stalled edge or a deselected continue write the array would corrupt those words. A reset in the middle of a burst checks that in-flight writes are dropped and that a following continue stays idle.

// File: rtl/nws_pkg.sv
package nws_pkg;
  localparam int LANE_W  = 8;
  localparam int LANES   = 4;
  localparam int DATA_W  = LANE_W * LANES;
  localparam int BURST_W = 2;
  localparam int NUM_CS  = 3;

  typedef logic [BURST_W-1:0] beat_t;

  // Low address bits of a burst beat: step counts continues since the load.
  function automatic beat_t burst_offset(input beat_t base, input beat_t step,
                                         input logic ilv);
    beat_t r;
    if (ilv) r = base ^ step;
    else     r = base + step;
    return r;
  endfunction

  // A load selects the device only when every chip select is asserted.
  function automatic logic cs_all(input logic [NUM_CS-1:0] cs);
    return &cs;
  endfunction
endpackage

// File: rtl/nws_cmd.sv
module nws_cmd
  import nws_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic [NUM_CS-1:0] chip_sel,
  input  logic              burst_cont,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              ilv_mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              s1_vld,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_lanes
);
  // burst state
  logic              bst_active;
  logic              bst_wr;
  logic              bst_ilv;
  logic [ADDR_W-1:0] bst_base;
  beat_t             bst_cnt;

  // named events
  logic              load_cmd;
  logic              sel_now;
  beat_t             nx_cnt;
  logic [ADDR_W-1:0] cont_addr;

  logic              d_vld;
  logic              d_wr;
  logic [ADDR_W-1:0] d_addr;
  logic [LANES-1:0]  d_lanes;

  assign load_cmd = !burst_cont;
  assign sel_now  = cs_all(chip_sel);

  always_comb begin
    nx_cnt    = bst_cnt + 1'b1;
    cont_addr = {bst_base[ADDR_W-1:BURST_W],
                 burst_offset(bst_base[BURST_W-1:0], nx_cnt, bst_ilv)};
    if (load_cmd) begin
      d_vld  = sel_now;
      d_wr   = !wr_n;
      d_addr = addr;
    end else begin
      d_vld  = bst_active;
      d_wr   = bst_wr;
      d_addr = cont_addr;
    end
    d_lanes = (d_vld && d_wr) ? ~lane_wr_n : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld     <= 1'b0;
      s1_wr      <= 1'b0;
      s1_addr    <= '0;
      s1_lanes   <= '0;
      bst_active <= 1'b0;
      bst_wr     <= 1'b0;
      bst_ilv    <= 1'b0;
      bst_base   <= '0;
      bst_cnt    <= '0;
    end else if (!clk_en_n) begin
      s1_vld   <= d_vld;
      s1_wr    <= d_wr;
      s1_addr  <= d_addr;
      s1_lanes <= d_lanes;
      if (load_cmd) begin
        bst_active <= sel_now;
        bst_wr     <= !wr_n;
        bst_ilv    <= ilv_mode;
        bst_base   <= addr;
        bst_cnt    <= '0;
      end else begin
        bst_cnt <= nx_cnt;
      end
    end
  end

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(s1_vld) && $stable(bst_active) && $stable(bst_cnt)));

  // R3
  desel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !burst_cont && (chip_sel != {NUM_CS{1'b1}})) |=> !s1_vld);

  // R9
  desel_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_cont && !bst_active) |=> (!s1_vld && !bst_active));

  // R6
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_cont) |=> (bst_cnt == beat_t'($past(bst_cnt) + 1'b1)));

  // R6
  beat_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_cont && bst_active) |=>
      (s1_addr[ADDR_W-1:BURST_W] == bst_base[ADDR_W-1:BURST_W]));
endmodule

// File: rtl/nws_stage.sv
module nws_stage
  import nws_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              in_vld,
  input  logic              in_wr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_lanes,
  output logic              out_vld,
  output logic              out_wr,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LANES-1:0]  out_lanes
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      out_wr    <= 1'b0;
      out_addr  <= '0;
      out_lanes <= '0;
    end else if (!clk_en_n) begin
      out_vld   <= in_vld;
      out_wr    <= in_wr;
      out_addr  <= in_addr;
      out_lanes <= in_lanes;
    end
  end

  // R2
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(out_vld) && $stable(out_wr)));
endmodule

// File: rtl/nws_array.sv
module nws_array
  import nws_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              op_vld,
  input  logic              op_wr,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [LANES-1:0]  op_lanes,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_vld
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] cur_word;

  assign wr_fire = !clk_en_n && op_vld && op_wr;
  assign rd_fire = !clk_en_n && op_vld && !op_wr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_fire && op_lanes[g]) mem[op_addr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign cur_word[g*LANE_W +: LANE_W] = mem[op_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld <= 1'b0;
    else if (!clk_en_n) rd_vld <= op_vld && !op_wr;
  end

  always_ff @(posedge clk) begin
    if (rd_fire) rd_word <= cur_word;
  end

  // R1
  read_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && op_vld && !op_wr) |=> rd_vld);

  // R7
  write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && op_vld && op_wr) |=> !rd_vld);

  // R2
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && rd_vld) |=> (rd_vld && $stable(rd_word)));
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import nws_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic [2:0]        chip_sel,
  input  logic              burst_cont,
  input  logic              wr_n,
  input  logic [3:0]        lane_wr_n,
  input  logic              ilv_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              out_en_n,
  output logic [31:0]       rdata,
  output logic              rdata_vld
);
  logic              s1_vld, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_lanes;
  logic              s2_vld, s2_wr;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_lanes;
  logic [DATA_W-1:0] rd_word;
  logic              rd_vld;

  nws_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .chip_sel(chip_sel),
    .burst_cont(burst_cont), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .ilv_mode(ilv_mode), .addr(addr),
    .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr), .s1_lanes(s1_lanes)
  );

  nws_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .in_vld(s1_vld), .in_wr(s1_wr), .in_addr(s1_addr), .in_lanes(s1_lanes),
    .out_vld(s2_vld), .out_wr(s2_wr), .out_addr(s2_addr), .out_lanes(s2_lanes)
  );

  nws_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .op_vld(s2_vld), .op_wr(s2_wr), .op_addr(s2_addr), .op_lanes(s2_lanes),
    .wdata(wdata), .rd_word(rd_word), .rd_vld(rd_vld)
  );

  assign rdata_vld = rd_vld && !out_en_n;
  assign rdata     = rdata_vld ? rd_word : '0;

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> !rdata_vld);
endmodule

// File: tb/pipe_sram_tb.sv
module pipe_sram_tb;
  localparam int AW = 4;
  localparam int NW = 16;
  localparam int HN = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en_n = 1'b0;
  logic [2:0]    chip_sel = 3'b000;
  logic          burst_cont = 1'b0;
  logic          wr_n = 1'b1;
  logic [3:0]    lane_wr_n = 4'hF;
  logic          ilv_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          out_en_n = 1'b0;
  logic [31:0]   rdata;
  logic          rdata_vld;

  always #10 clk = ~clk;

  pipe_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .chip_sel(chip_sel),
    .burst_cont(burst_cont), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .ilv_mode(ilv_mode), .addr(addr), .wdata(wdata), .out_en_n(out_en_n),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int          kind_h [HN];  // 0 none, 1 read, 2 write
  int          addr_h [HN];
  logic [3:0]  wen_h  [HN];
  logic [31:0] wd_h   [HN];
  logic [31:0] exp_h  [HN];
  string       tag_h  [HN];
  logic [31:0] mdl    [NW];

  int n = 0;
  int b_act = 0, b_wr = 0, b_base = 0, b_k = 0, b_ilv = 0;
  bit ilv_drv = 1'b0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] wen);
    logic [31:0] r;
    r = old;
    for (int i = 0; i < 4; i++) if (!wen[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic issue(input bit ld, input bit wr, input logic [2:0] cs, input int a,
                       input logic [3:0] wen, input string tag);
    int c, kd, ka, p, lo;
    c = n;
    if (ld) begin
      b_act  = (cs == 3'b111) ? 1 : 0;
      b_wr   = wr ? 1 : 0;
      b_base = a;
      b_k    = 0;
      b_ilv  = ilv_drv ? 1 : 0;
      kd     = (b_act != 0) ? (wr ? 2 : 1) : 0;
      ka     = a;
    end else if (b_act != 0) begin
      b_k = (b_k + 1) % 4;
      lo  = (b_ilv != 0) ? ((b_base % 4) ^ b_k) : (((b_base % 4) + b_k) % 4);
      ka  = (b_base / 4) * 4 + lo;
      kd  = (b_wr != 0) ? 2 : 1;
    end else begin
      kd = 0;
      ka = 0;
    end
    kind_h[c] = kd;
    addr_h[c] = ka;
    wen_h[c]  = wen;
    wd_h[c]   = $urandom;
    tag_h[c]  = tag;
    clk_en_n   = 1'b0;
    burst_cont = !ld;
    wr_n       = !wr;
    chip_sel   = cs;
    addr       = AW'(a);
    lane_wr_n  = wen;
    ilv_mode   = ilv_drv;
    wdata      = (c >= 2 && kind_h[c-2] == 2) ? wd_h[c-2] : $urandom;
    @(posedge clk);
    p = c - 2;
    if (p >= 0) begin
      if (kind_h[p] == 2) mdl[addr_h[p]] = merge(mdl[addr_h[p]], wd_h[p], wen_h[p]);
      if (kind_h[p] == 1) exp_h[p] = mdl[addr_h[p]];
    end
    n++;
    @(negedge clk);
    if (p >= 0) begin
      if (kind_h[p] == 1) begin
        chk(tag_h[p], {31'b0, rdata_vld}, 32'd1);
        chk(tag_h[p], rdata, exp_h[p]);
        out_en_n = 1'b1;
        #1;
        chk("R7 output disabled", {31'b0, rdata_vld}, 32'd0);
        chk("R7 output disabled data", rdata, 32'd0);
        out_en_n = 1'b0;
        #1;
      end else begin
        chk(tag_h[p], {31'b0, rdata_vld}, 32'd0);
        chk(tag_h[p], rdata, 32'd0);
      end
    end
  endtask

  task automatic stall(input string tag);
    logic [31:0] sd;
    logic        sv;
    sd = rdata;
    sv = rdata_vld;
    clk_en_n   = 1'b1;
    burst_cont = 1'($urandom);
    wr_n       = 1'($urandom);
    chip_sel   = 3'($urandom);
    addr       = AW'($urandom);
    lane_wr_n  = 4'($urandom);
    wdata      = $urandom;
    ilv_mode   = 1'($urandom);
    @(posedge clk);
    @(negedge clk);
    chk(tag, {31'b0, rdata_vld}, {31'b0, sv});
    chk(tag, rdata, sd);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 reset output idle", {31'b0, rdata_vld}, 32'd0);
    rst_n = 1'b1;
    if (n >= 2) begin kind_h[n-2] = 0; tag_h[n-2] = "R10 pipeline flushed"; end
    if (n >= 1) begin kind_h[n-1] = 0; tag_h[n-1] = "R10 pipeline flushed"; end
    b_act = 0;
  endtask

  task automatic idle2();
    issue(1'b1, 1'b0, 3'b000, 0, 4'hF, "R3 idle deselect");
    issue(1'b1, 1'b0, 3'b000, 0, 4'hF, "R3 idle deselect");
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < HN; i++) kind_h[i] = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset state", {31'b0, rdata_vld}, 32'd0);
    chk("R10 reset data", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: continue straight after reset is a deselect
    issue(1'b0, 1'b1, 3'b111, 0, 4'h0, "R10 continue after reset");

    // R1: fill and read back
    for (int a = 0; a < NW; a++) issue(1'b1, 1'b1, 3'b111, a, 4'h0, "R1 fill write");
    for (int a = 0; a < NW; a++) issue(1'b1, 1'b0, 3'b111, a, 4'hF, "R1 read latency");
    idle2();

    // R3: chip select sweep
    for (int cs = 0; cs < 8; cs++) issue(1'b1, 1'b0, 3'(cs), cs, 4'hF, "R3 chip select read");
    for (int cs = 0; cs < 7; cs++) issue(1'b1, 1'b1, 3'(cs), 5, 4'h0, "R3 deselected write");
    issue(1'b1, 1'b0, 3'b111, 5, 4'hF, "R3 word intact after deselected writes");

    // R4 / R8: every byte mask, read on the next clock
    for (int m = 0; m < 16; m++) begin
      issue(1'b1, 1'b1, 3'b111, m, 4'(m), "R4 lane write");
      issue(1'b1, 1'b0, 3'b111, m, 4'hF, "R8 read after lane write");
    end
    for (int a = 0; a < NW; a++) issue(1'b1, 1'b0, 3'b111, a, 4'hF, "R4 lane sweep");

    // R5: alternating traffic
    for (int i = 0; i < 24; i++) begin
      issue(1'b1, 1'b1, 3'b111, i % NW, 4'($urandom), "R5 alternating write");
      issue(1'b1, 1'b0, 3'b111, (i * 5) % NW, 4'hF, "R5 alternating read");
    end
    for (int a = 0; a < NW; a++) issue(1'b1, 1'b0, 3'b111, a, 4'hF, "R5 sweep");

    // R6: bursts over every base, both orders, both types
    for (int il = 0; il < 2; il++)
      for (int base = 0; base < NW; base++)
        for (int w = 0; w < 2; w++) begin
          ilv_drv = (il != 0);
          issue(1'b1, w != 0, 3'b111, base, 4'($urandom), "R6 burst load");
          for (int j = 0; j < 5; j++) begin
            ilv_drv = 1'($urandom);
            issue(1'b0, w == 0, 3'($urandom), int'($urandom % NW), 4'($urandom),
                  "R6 burst beat");
          end
        end
    ilv_drv = 1'b0;
    for (int a = 0; a < NW; a++) issue(1'b1, 1'b0, 3'b111, a, 4'hF, "R6 burst result sweep");

    // R9: deselected bursts
    issue(1'b1, 1'b0, 3'b110, 2, 4'hF, "R9 deselect load");
    for (int j = 0; j < 3; j++) issue(1'b0, 1'b0, 3'b111, 2, 4'hF, "R9 continue after deselect");
    issue(1'b1, 1'b1, 3'b011, 4, 4'h0, "R9 deselect write load");
    for (int j = 0; j < 3; j++) issue(1'b0, 1'b1, 3'b111, 4, 4'h0, "R9 no write during deselected burst");
    for (int a = 4; a < 8; a++) issue(1'b1, 1'b0, 3'b111, a, 4'hF, "R9 words intact");

    // R2: stalls inside write and read slots
    issue(1'b1, 1'b1, 3'b111, 9, 4'h0, "R2 write before stall");
    stall("R2 stall hold");
    issue(1'b1, 1'b0, 3'b111, 9, 4'hF, "R2 read across stall");
    stall("R2 stall hold");
    stall("R2 stall hold");
    issue(1'b1, 1'b1, 3'b111, 10, 4'b0101, "R2 write before stall");
    issue(1'b1, 1'b0, 3'b111, 10, 4'hF, "R2 read after stalled write");
    stall("R2 stall hold");
    issue(1'b1, 1'b0, 3'b111, 3, 4'hF, "R2 read after stall");
    stall("R2 stall hold in read slot");
    stall("R2 stall hold in read slot");
    idle2();
    for (int a = 8; a < 12; a++) issue(1'b1, 1'b0, 3'b111, a, 4'hF, "R2 no write while stalled");

    // R10: reset in flight
    issue(1'b1, 1'b0, 3'b111, 3, 4'hF, "R10 read before reset");
    issue(1'b1, 1'b1, 3'b111, 6, 4'h0, "R10 write before reset");
    do_reset();
    issue(1'b0, 1'b1, 3'b111, 6, 4'h0, "R10 burst cleared");
    issue(1'b1, 1'b0, 3'b111, 6, 4'hF, "R10 flushed write not stored");
    idle2();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule